// File: doc/BRIEF.md
# Interval Timer Peripheral

This peripheral sits on a 16-bit memory-mapped bus and raises an interrupt request once a programmed number of fixed 100 ms intervals has passed. Software writes the number of intervals to a count port, then sets bit 0 of a control port to launch the countdown. A prescaler, sized from the clock frequency and the interval length, produces one tick per interval. The down-counter advances on each tick.

When the countdown expires, the timer stops itself and raises an interrupt request carrying the fixed vector number 15. The request is held until the interrupt controller pulses the acknowledge input. Writing 0 to the control bit cancels a countdown without any interrupt. Reads return the running flag from the control port and the remaining interval count from the count port. Arbitration, masking and the bus master are outside this block.

Top module: `interval_timer`

## Requirements
- R1: After reset the control port reads 0, the count port reads 0 and `irq_req` is low.
- R2: `irq_vec` always presents the vector number 15.
- R3: A bus write to address FFF7h with bit 0 set starts the timer. Afterwards FFF7h reads 1 in bit 0 (all other bits 0), and FFF6h reads the value last written to FFF6h.
- R4: While the timer is running, the value read at FFF6h drops by one at the end of each interval of `CLK_HZ*INTERVAL_MS/1000` clock cycles, counted from the start write.
- R5: A start with count N (N at least 1) raises `irq_req` exactly N intervals after the start write. In the same cycle the running bit clears and the count reads 0. It is not raised one cycle earlier.
- R6: A start with count 0 raises `irq_req` at the end of the first interval.
- R7: A write of 0 in bit 0 to FFF7h stops the countdown. The running bit reads 0, the remaining count is frozen, and no interrupt is raised afterwards.
- R8: `irq_req` stays high until `irq_ack` is high at a clock edge. After that edge it is low.
- R9: A write to FFF6h while the timer runs does not change the countdown in progress; it takes effect at the next start.
- R10: Writes to addresses other than FFF6h and FFF7h change nothing, and reads of such addresses return 0.
- R11: Writing bit 0 = 1 while the timer is running reloads the count and restarts the interval from its beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address, also selects the read data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vec | output | 8 | Interrupt vector number, fixed at 15 |
| irq_ack | input | 1 | Interrupt acknowledge pulse |

## Verification
The hardest case to reach is a control write that lands partway through an interval while a countdown is live. A cancel must stop the request from ever appearing. A restart must realign the prescaler so that the next tick comes one full interval after the write and not at the old phase. The stimulus starts a countdown, waits a few cycles past the first tick so that the prescaler phase is nonzero, then issues the stop or restart write. It then samples the request on both sides of the cycle where the interval boundary would fall under each phase.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int TMR_WORD_W = 16;
  localparam int TMR_VEC_W  = 8;

  typedef logic [TMR_WORD_W-1:0] tmr_word_t;

  // true when the next tick ends the countdown (counts 0 and 1 both expire)
  function automatic logic f_is_final(input tmr_word_t rem);
    return (rem == tmr_word_t'(0)) || (rem == tmr_word_t'(1));
  endfunction

  function automatic tmr_word_t f_step_down(input tmr_word_t rem);
    return rem - tmr_word_t'(1);
  endfunction

  function automatic tmr_word_t f_read_mux(input logic hit_ctrl, input logic hit_cnt,
                                           input logic running, input tmr_word_t rem);
    tmr_word_t r;
    r = '0;
    if (hit_ctrl)     r = {{(TMR_WORD_W-1){1'b0}}, running};
    else if (hit_cnt) r = rem;
    return r;
  endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int TICK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic enable,
  output logic tick
);

  generate
    if (TICK_CYCLES <= 1) begin : g_direct
      assign tick = enable && !restart;
    end else begin : g_count
      localparam int PW = $clog2(TICK_CYCLES);
      localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

      logic [PW-1:0] phase;

      always_ff @(posedge clk) begin
        if (!rst_n)                phase <= '0;
        else if (restart || !enable) phase <= '0;
        else if (phase == LAST)    phase <= '0;
        else                       phase <= phase + 1'b1;
      end

      assign tick = enable && !restart && (phase == LAST);

      // R4: the phase never leaves the interval range
      a_r4_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);
      // R11: a restart puts the phase back to the start of an interval
      a_r11_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));
    end
  endgenerate

endmodule

// File: rtl/timer_downcount.sv
module timer_downcount
  import timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  tmr_word_t load_val,
  input  logic      stop,
  input  logic      tick,
  output logic      running,
  output tmr_word_t remaining,
  output logic      expire
);

  logic step_event;

  assign step_event = running && tick && !load && !stop;
  assign expire     = step_event && f_is_final(remaining);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      remaining <= '0;
    end else if (load) begin
      running   <= 1'b1;
      remaining <= load_val;
    end else if (stop) begin
      running   <= 1'b0;
    end else if (step_event) begin
      if (f_is_final(remaining)) begin
        running   <= 1'b0;
        remaining <= '0;
      end else begin
        remaining <= f_step_down(remaining);
      end
    end
  end

  // R4: a non-final tick lowers the count by exactly one
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_event && !f_is_final(remaining)) |=> (remaining == $past(remaining) - 1'b1));
  // R5: expiry leaves the timer stopped with zero remaining
  a_r5_expire_stops: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!running && remaining == '0));
  // R7: the running flag only drops on a stop write or an expiry
  a_r7_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(stop) || $past(expire)));
  // R7: remaining is frozen while stopped
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(remaining));

endmodule

// File: rtl/timer_irq_hold.sv
module timer_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (set) irq <= 1'b1;
    else if (ack) irq <= 1'b0;
  end

  // R8: request holds until acknowledged
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  // R8: acknowledge without a new expiry clears the request
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !irq);
  // R5: the request rises only after an expiry
  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set));

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter longint         CLK_HZ      = 100_000_000,
  parameter int             INTERVAL_MS = 100,
  parameter logic [15:0]    CTRL_ADDR   = 16'hFFF7,
  parameter logic [15:0]    COUNT_ADDR  = 16'hFFF6,
  parameter int             IRQ_VECTOR  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_req,
  output logic [7:0]  irq_vec,
  input  logic        irq_ack
);

  localparam longint TICK_L      = (CLK_HZ * INTERVAL_MS) / 1000;
  localparam int     TICK_CYCLES = (TICK_L < 1) ? 1 : int'(TICK_L);

  // named bus events
  logic      hit_ctrl, hit_cnt;
  logic      wr_ctrl, wr_cnt;
  logic      start_req, stop_req;
  logic      tick, expire, running;
  tmr_word_t count_set, remaining;

  assign hit_ctrl  = (bus_addr == CTRL_ADDR);
  assign hit_cnt   = (bus_addr == COUNT_ADDR);
  assign wr_ctrl   = bus_wr && hit_ctrl;
  assign wr_cnt    = bus_wr && hit_cnt;
  assign start_req = wr_ctrl && bus_wdata[0];
  assign stop_req  = wr_ctrl && !bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      count_set <= '0;
    else if (wr_cnt) count_set <= bus_wdata;
  end

  timer_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_ctrl),
    .enable  (running),
    .tick    (tick)
  );

  timer_downcount u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_req),
    .load_val  (count_set),
    .stop      (stop_req),
    .tick      (tick),
    .running   (running),
    .remaining (remaining),
    .expire    (expire)
  );

  timer_irq_hold u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire),
    .ack   (irq_ack),
    .irq   (irq_req)
  );

  assign bus_rdata = f_read_mux(hit_ctrl, hit_cnt, running, remaining);
  assign irq_vec   = TMR_VEC_W'(IRQ_VECTOR);

  // R3: a start write leaves the timer running with the programmed count
  a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (running && remaining == $past(count_set)));
  // R7: a stop write leaves the timer idle and raises nothing next cycle
  a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !irq_req) |=> (!running && !irq_req));
  // R9: a count write alone does not disturb the countdown
  a_r9_count_write_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !tick) |=> $stable(remaining));
  // R10: a read of an unmapped address returns zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ctrl && !hit_cnt) |-> (bus_rdata == '0));

endmodule

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;

  localparam int T = 8; // cycles per interval with the parameters below

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        irq_ack = 1'b0;

  always #5 clk = ~clk;

  interval_timer #(.CLK_HZ(80), .INTERVAL_MS(100)) i_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 request, 2 vector
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     chk_ev;
  int       n_checks = 0;
  int       n_errors = 0;
  bit       done = 0;

  // monitor: pops expectations and compares with what the design shows
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = bus_rdata;
          1:       act = {15'h0, irq_req};
          default: act = {8'h00, irq_vec};
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s: actual %h expected %h at %0t", it.tag, act, it.exp, $time);
        end
      end
    end
  end

  task automatic push_chk(input int kind, input logic [15:0] exp, input string tag);
    sb_item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    #0.01;
    sb_q.push_back(it);
    -> chk_ev;
    #0.01;
  endtask

  task automatic chk_rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    push_chk(0, exp, tag);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    push_chk(1, {15'h0, exp}, tag);
  endtask

  // called just after a falling edge; the write lands at the next rising edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state, R2 vector
    chk_rd(16'hFFF7, 16'h0000, "R1 ctrl after reset");
    chk_rd(16'hFFF6, 16'h0000, "R1 count after reset");
    chk_irq(1'b0, "R1 request after reset");
    push_chk(2, 16'h000F, "R2 vector");

    // R3/R4/R5: count 3
    wr(16'hFFF6, 16'd3);
    wr(16'hFFF7, 16'h0001);
    chk_rd(16'hFFF7, 16'h0001, "R3 running bit");
    chk_rd(16'hFFF6, 16'd3, "R3 loaded count");
    wait_cyc(T-1);
    chk_rd(16'hFFF6, 16'd3, "R4 count before first tick");
    wait_cyc(1);
    chk_rd(16'hFFF6, 16'd2, "R4 count after first tick");
    wait_cyc(2*T-1);
    chk_irq(1'b0, "R5 no request one cycle early");
    wait_cyc(1);
    chk_irq(1'b1, "R5 request at expiry");
    chk_rd(16'hFFF7, 16'h0000, "R5 running bit cleared");
    chk_rd(16'hFFF6, 16'h0000, "R5 count zero");
    push_chk(2, 16'h000F, "R2 vector during request");

    // R8 hold and acknowledge
    wait_cyc(20);
    chk_irq(1'b1, "R8 request held");
    ack_irq();
    chk_irq(1'b0, "R8 request cleared by ack");

    // R6 count 0
    wr(16'hFFF6, 16'd0);
    wr(16'hFFF7, 16'h0001);
    wait_cyc(T-1);
    chk_irq(1'b0, "R6 no request before first tick");
    wait_cyc(1);
    chk_irq(1'b1, "R6 request on first tick");
    ack_irq();

    // R7 cancel mid-interval
    wr(16'hFFF6, 16'd2);
    wr(16'hFFF7, 16'h0001);
    wait_cyc(T+2);
    wr(16'hFFF7, 16'h0000);
    chk_rd(16'hFFF7, 16'h0000, "R7 running bit after stop");
    chk_rd(16'hFFF6, 16'd1, "R7 count frozen");
    wait_cyc(3*T);
    chk_irq(1'b0, "R7 no request after stop");
    chk_rd(16'hFFF6, 16'd1, "R7 count still frozen");

    // R9 count write during countdown
    wr(16'hFFF6, 16'd5);
    wr(16'hFFF7, 16'h0001);
    wait_cyc(2);
    wr(16'hFFF6, 16'd1);
    chk_rd(16'hFFF6, 16'd5, "R9 remaining unchanged");
    wait_cyc(5*T-4);
    chk_irq(1'b0, "R9 no early request");
    wait_cyc(1);
    chk_irq(1'b1, "R9 request after original count");
    ack_irq();

    // R11 restart mid-interval
    wr(16'hFFF6, 16'd2);
    wr(16'hFFF7, 16'h0001);
    wait_cyc(T+3);
    chk_rd(16'hFFF6, 16'd1, "R11 count before restart");
    wr(16'hFFF7, 16'h0001);
    chk_rd(16'hFFF6, 16'd2, "R11 count reloaded");
    wait_cyc(2*T-1);
    chk_irq(1'b0, "R11 no request at old phase");
    wait_cyc(1);
    chk_irq(1'b1, "R11 request after full restart");
    ack_irq();

    // R10 unmapped address
    wr(16'hFFF5, 16'h0001);
    chk_rd(16'hFFF7, 16'h0000, "R10 unmapped write did not start");
    chk_rd(16'hFFF5, 16'h0000, "R10 unmapped read zero");
    wait_cyc(2*T);
    chk_irq(1'b0, "R10 no request");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule